// File: doc/BRIEF.md
# Password-Guarded Watchdog Timer

This block is a watchdog that counts prescaled ticks. Software keeps it alive by writing the control register. When the count runs out, the block does one of two things, chosen by a mode bit: it pulses an interrupt, or it asks the system for a reset. Every control write must carry a fixed 8-bit key in bits 15:8. A write with any other key is treated as a fault in its own right, and it triggers the configured action at once.

Two sticky status bits record what caused the last action. One shows that the watchdog acted, as opposed to an external reset. The other shows that the action came from a bad key. Both bits survive the reset the watchdog itself requests. Only the external reset input clears them. The block's own configuration returns to zero when its reset request ends.

Top module: `wdg_guard`

## Requirements
- R1: After the external reset, rd_data_o reads 0 and irq_o and rst_req_o are low.
- R2: A write with 0x47 in bits 15:8 loads the tick select from bits 2:0, the enable from bit 3 and the mode from bit 4. Readback gives those bits in the same places, with bit 5 = watchdog-cause, bit 6 = key-fault and all other bits zero.
- R3: The tick select codes 0..7 divide the clock by 2, 4, 8, 64, 128, 1024, 2048 and 4096. When enabled, a timeout occurs 4096 ticks (4096 × divider clocks) after the last accepted write, and every accepted write restarts that interval.
- R4: In mode 0, a timeout makes irq_o high for exactly one clock, in the cycle after the timeout edge.
- R5: In mode 1, a timeout holds rst_req_o high for exactly 4 clocks. When it drops, bits 4:0 read zero.
- R6: A write with any other key leaves bits 4:0 and the count unchanged. It fires the configured action on the next edge, whether or not the watchdog is enabled.
- R7: Every watchdog action sets bit 5. Bit 6 is set when the action came from a bad key and cleared when it came from a timeout.
- R8: Bits 5 and 6 survive the watchdog's own reset request and are cleared only by rst_ni.
- R9: If an accepted write and a timeout fall in the same cycle, the write wins and no action fires. If a bad-key write and a timeout coincide, exactly one action fires and bit 6 is set.
- R10: While rst_req_o is high, writes are ignored and the count is frozen.
- R11: With the enable bit clear, no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | External reset, active low, asynchronous; also clears the cause bits |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 32 | Write data: key in 15:8, mode 4, enable 3, tick select 2:0 |
| rd_data_o | output | 32 | Control/status readback |
| irq_o | output | 1 | Timeout or fault interrupt pulse (mode 0) |
| rst_req_o | output | 1 | System reset request (mode 1), held 4 clocks |

## Verification
The functions that can collide are the feed and the timeout. The bench counts clocks from an accepted write and places a second write exactly on the edge where the count would wrap. It then confirms that no interrupt appears. It repeats the collision with a bad-key write, and there it expects one interrupt with the key-fault bit set. A behavioural model that counts enabled clocks since the last feed is compared against every output on every clock. This exposes any action that is early, late or duplicated.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam logic [7:0] KEY      = 8'h47;
    localparam int         PRE_W    = 12;
    localparam int         RST_HOLD = 4;
    localparam int         HOLD_W   = $clog2(RST_HOLD + 1);

    // log2 of the clock divider for each tick select code
    function automatic int div_shift(input int code);
        case (code)
            0:       return 1;
            1:       return 2;
            2:       return 3;
            3:       return 6;
            4:       return 7;
            5:       return 10;
            6:       return 11;
            default: return 12;
        endcase
    endfunction

    typedef struct packed {
        logic [2:0]        sel;
        logic              en;
        logic              mode;
        logic              cause;
        logic              pwf;
        logic              irq;
        logic [HOLD_W-1:0] hold;
    } wdg_state_t;
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale
    import wdg_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic [2:0] sel_i,
    output logic       tick_o
);
    localparam int NSEL = 8;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [NSEL-1:0]  cand;

    for (genvar g = 0; g < NSEL; g++) begin : g_tap
        localparam int K = div_shift(g);
        assign cand[g] = &pre_q[K-1:0];
    end

    assign tick_o = run_i && !clr_i && cand[sel_i];

    always_comb begin
        pre_d = pre_q;
        if (clr_i)      pre_d = '0;
        else if (run_i) pre_d = pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end

    assert_tick_needs_run_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> $changed(pre_q));
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
    parameter int CNT_W = 12
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic clr_i,
    output logic wrap_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign wrap_o = tick_i && (&cnt_q);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (tick_i) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assert_wrap_to_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
    import wdg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_en_i,
    input  logic [31:0] wr_data_i,
    output logic [31:0] rd_data_o,
    output logic        irq_o,
    output logic        rst_req_o
);
    wdg_state_t s_d, s_q;
    logic holding, key_ok, wr_good, wr_bad, fire, feed, hold_end;
    logic run, clr, tick, wrap;
    logic unused_bits;

    assign unused_bits = ^{wr_data_i[31:16], wr_data_i[7:5]};
    assign run = s_q.en && !holding;
    assign clr = feed || hold_end;

    wdg_prescale u_pre (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (run),
        .clr_i (clr),
        .sel_i (s_q.sel),
        .tick_o(tick)
    );

    wdg_count #(.CNT_W(CNT_W)) u_cnt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_i(tick),
        .clr_i (clr),
        .wrap_o(wrap)
    );

    always_comb begin
        s_d      = s_q;
        s_d.irq  = 1'b0;
        feed     = 1'b0;
        hold_end = 1'b0;
        holding  = (s_q.hold != '0);
        key_ok   = (wr_data_i[15:8] == KEY);
        wr_good  = wr_en_i && !holding && key_ok;
        wr_bad   = wr_en_i && !holding && !key_ok;
        fire     = wr_bad || (wrap && !wr_good);

        if (holding) begin
            s_d.hold = s_q.hold - HOLD_W'(1);
            if (s_q.hold == HOLD_W'(1)) begin
                s_d.sel  = '0;
                s_d.en   = 1'b0;
                s_d.mode = 1'b0;
                hold_end = 1'b1;
            end
        end

        if (wr_good) begin
            s_d.sel  = wr_data_i[2:0];
            s_d.en   = wr_data_i[3];
            s_d.mode = wr_data_i[4];
            feed     = 1'b1;
        end

        if (fire) begin
            s_d.cause = 1'b1;
            s_d.pwf   = wr_bad;
            if (s_q.mode) s_d.hold = HOLD_W'(RST_HOLD);
            else          s_d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rd_data_o = {25'd0, s_q.pwf, s_q.cause, s_q.mode, s_q.en, s_q.sel};
    assign irq_o     = s_q.irq;
    assign rst_req_o = holding;

    assert_readback_clean_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[31:7] == '0);
    assert_one_action_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(irq_o && rst_req_o));
    assert_hold_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_req_o) |-> ($past(rst_req_o, 2) && $past(rst_req_o, 3) && $past(rst_req_o, 4)));
    assert_cfg_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_req_o) |-> (rd_data_o[4:0] == '0));
    assert_pwf_has_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[6] |-> rd_data_o[5]);
    assert_cause_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(rd_data_o[5]));
    assert_frozen_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_req_o && $past(rst_req_o) && !$fell(rst_req_o)) |-> $stable(rd_data_o));
endmodule

// File: tb/sim_wdg_guard.sv
module sim_wdg_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq, rst_req;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    wdg_guard u0 (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .irq_o(irq), .rst_req_o(rst_req)
    );

    // behavioural reference
    int m_sel, m_en, m_mode, m_cause, m_pwf, m_irq, m_hold, m_since;

    function automatic int divider(input int s);
        case (s)
            0: return 2;    1: return 4;    2: return 8;    3: return 64;
            4: return 128;  5: return 1024; 6: return 2048; default: return 4096;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sel = 0; m_en = 0; m_mode = 0; m_cause = 0; m_pwf = 0;
            m_irq = 0; m_hold = 0; m_since = 0;
        end else begin
            int  hold_now, mode_now;
            bit  good, bad, tout, fire;
            hold_now = m_hold;
            mode_now = m_mode;
            good = wr_en && hold_now == 0 && wr_data[15:8] == 8'h47;
            bad  = wr_en && hold_now == 0 && wr_data[15:8] != 8'h47;
            tout = hold_now == 0 && m_en != 0 && m_since == 4096 * divider(m_sel) - 1;
            fire = bad || (tout && !good);
            m_irq = 0;
            if (m_en != 0 && hold_now == 0)
                m_since = tout ? 0 : m_since + 1;
            if (hold_now > 0) begin
                m_hold = hold_now - 1;
                if (hold_now == 1) begin
                    m_sel = 0; m_en = 0; m_mode = 0; m_since = 0;
                end
            end
            if (good) begin
                m_sel = int'(wr_data[2:0]); m_en = int'(wr_data[3]);
                m_mode = int'(wr_data[4]); m_since = 0;
            end
            if (fire) begin
                m_cause = 1; m_pwf = bad ? 1 : 0;
                if (mode_now != 0) m_hold = 4; else m_irq = 1;
            end
        end
    end

    function automatic logic [31:0] exp_rd();
        return {25'd0, 1'(m_pwf), 1'(m_cause), 1'(m_mode), 1'(m_en), 3'(m_sel)};
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rd_data !== exp_rd() || irq !== 1'(m_irq) || rst_req !== (m_hold != 0)) begin
                errors++;
                $display("FAIL %s model: rd=%h irq=%b rst=%b expected rd=%h irq=%0d rst=%0d",
                         tag, rd_data, irq, rst_req, exp_rd(), m_irq, m_hold != 0);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_irq(input int lim, output int n);
        n = 0;
        while (!irq && n < lim) begin @(negedge clk); n++; end
    endtask

    task automatic wait_rst(input int lim, output int n);
        n = 0;
        while (!rst_req && n < lim) begin @(negedge clk); n++; end
    endtask

    initial begin : wdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd", rd_data, 32'h0);
        chk("R1 out", {30'd0, irq, rst_req}, 32'h0);

        tag = "R2";
        wr(32'h0000_4708);
        chk("R2 readback", rd_data, 32'h0000_0008);

        tag = "R3";
        wait_irq(20000, n);
        chk("R3 R4 div2 period", n, 32'd8192);
        @(negedge clk);
        chk("R4 one-cycle pulse", {31'd0, irq}, 32'h0);
        chk("R7 timeout cause", rd_data[6:5], 32'h1);

        n = 0;
        for (int k = 0; k < 3; k++) begin
            int c;
            wr(32'h0000_4708);
            c = 0;
            repeat (5000) begin @(negedge clk); if (irq) c++; end
            n += c;
        end
        chk("R3 feed keeps quiet", n, 32'd0);

        wr(32'h0000_4709);
        wait_irq(40000, n);
        chk("R3 div4 period", n, 32'd16384);
        wr(32'h0000_470A);
        wait_irq(40000, n);
        chk("R3 div8 period", n, 32'd32768);

        tag = "R6";
        wr(32'h0000_4708);
        repeat (10) @(negedge clk);
        wr(32'h0000_4608);
        chk("R6 bad key fires", {31'd0, irq}, 32'h1);
        chk("R6 R7 cfg kept, fault flagged", rd_data, 32'h0000_0068);
        wr(32'h0000_4700);
        wr(32'h0000_1234);
        chk("R6 disabled bad key fires", {31'd0, irq}, 32'h1);

        tag = "R9";
        wr(32'h0000_4708);
        repeat (8191) @(negedge clk);
        wr(32'h0000_4708);
        n = 0;
        repeat (20) begin @(negedge clk); if (irq) n++; end
        chk("R9 feed beats timeout", n, 32'd0);
        wr(32'h0000_4708);
        repeat (8191) @(negedge clk);
        wr(32'h0000_0008);
        chk("R9 collided fault irq", {31'd0, irq}, 32'h1);
        @(negedge clk);
        chk("R9 single action", {31'd0, irq}, 32'h0);
        chk("R9 fault flag", rd_data[6:5], 32'h3);

        tag = "R5";
        wr(32'h0000_4718);
        wait_rst(20000, n);
        chk("R5 reset after period", n, 32'd8192);
        wr(32'h0000_470B);
        n = 1;
        while (rst_req && n < 10) begin @(negedge clk); n++; end
        chk("R5 hold length", n, 32'd4);
        chk("R10 R5 cfg cleared, cause kept", rd_data, 32'h0000_0020);

        tag = "R11";
        n = 0;
        repeat (9000) begin @(negedge clk); if (irq || rst_req) n++; end
        chk("R11 disabled quiet", n, 32'd0);

        tag = "R8";
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 external reset clears cause", rd_data, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule